// File: doc/BRIEF.md
# Programmable divider phase-frequency detector

This block divides two streams of single-cycle enables by programmable values and compares the divided events in a three-state phase-frequency detector. Both streams arrive in the system clock domain. One stream is the reference, divided by a 14-bit value. The other is the feedback, divided by a 13-bit value. The detector drives digital pump-up and pump-down requests. A minimum overlap pulse keeps both requests active for a few clocks even when the two events line up exactly. This removes any dead zone around zero phase error.

A digital lock flag watches how wide each comparison is. A monitor pin can show the lock flag, either divided event stream, or a constant level. A chip-enable input powers the block down. While it is low, the dividers, detector and lock logic are held cleared and the pump output is reported as high impedance. With both divide values at 1 the block is a plain phase-frequency detector.

The inputs are plain enables, not a data stream. There is no back-pressure: every enable that arrives while the block is enabled is counted.

Top module: `pfd_synth_core`

## Requirements
- R1: After reset is released, with chip enable high, pump_up, pump_dn, pump_hiz and lock_flag are all 0.
- R2: The reference divider emits one divided event for every r_div input enables. An r_div value of 0 acts as 1.
- R3: The feedback divider emits one divided event for every n_div input enables. An n_div value of 0 acts as 1.
- R4: A divide value is captured only at a terminal count, so a new value takes effect from the following period. After reset or power-down, the captured value is 1, so the first enable produces a divided event.
- R5: With both divide values at 1 and the two enables in the same cycle, pump_up and pump_dn rise together two cycles after the enable. Both stay high for exactly the overlap width.
- R6: When one divided event leads the other by d cycles, the leading request is high for d plus the overlap width. The trailing request is high for the overlap width. Both fall in the same cycle.
- R7: The overlap width is abp_sel clock cycles (1 to 3). An abp_sel value of 0 acts as 1.
- R8: A comparison passes when its widest request lasts at most the overlap width plus one cycle. lock_flag rises after 5 consecutive passing comparisons. It falls on the first failing comparison.
- R9: mon_out follows mon_sel as follows: 0 gives low, 1 gives lock_flag, 2 gives the divided reference events, 3 gives the divided feedback events, and 4 to 7 give high.
- R10: When chip_en is low, pump_hiz is 1 and both requests are 0 in the same cycle. lock_flag clears on the next edge. Divider counts and any pending request are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | High to run; low powers down |
| ref_tick | input | 1 | Reference enable, one cycle per edge |
| fb_tick | input | 1 | Feedback enable, one cycle per edge |
| r_div | input | 14 | Reference divide value |
| n_div | input | 13 | Feedback divide value |
| abp_sel | input | 2 | Overlap width in clocks |
| mon_sel | input | 3 | Monitor source select |
| pump_up | output | 1 | Up request |
| pump_dn | output | 1 | Down request |
| pump_hiz | output | 1 | Pump output in high impedance |
| lock_flag | output | 1 | Digital lock indication |
| mon_out | output | 1 | Monitor output |

## Verification
The bench measures each pump burst and compares it with the widths predicted from the programmed offset and overlap. An off-by-one in the overlap counter, or a reset that ignores the overlap, shows up as a width mismatch. It checks that the lock flag stays low after four good comparisons and rises on the fifth. A counter that locks one comparison early or late, or that fails to drop on a wide pulse, is caught there. It reprograms the divide values while running and programs zero. A design that applied the new value at once, or that stalled on zero, would give the wrong monitor pulse count. It also drops chip enable while an up request is pending. A design that kept the stale request would produce a widened burst after re-enable.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int MON_W = 3;

  typedef enum logic [MON_W-1:0] {
    MON_LOW  = 3'd0,
    MON_LOCK = 3'd1,
    MON_REF  = 3'd2,
    MON_FB   = 3'd3
  } mon_sel_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] div_in,
  output logic         pulse
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] div_lat;
  logic [W-1:0] div_eff;

  assign div_eff = (div_in == '0) ? ONE : div_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_lat <= ONE;
      pulse   <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      div_lat <= ONE;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == div_lat - ONE) begin
          cnt     <= '0;
          div_lat <= div_eff;
          pulse   <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  // R2 R3
  div_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick && en));

  // R4
  div_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_lat);
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int ABP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ref_p,
  input  logic             fb_p,
  input  logic [ABP_W-1:0] abp_eff,
  output logic             up,
  output logic             dn,
  output logic             done
);
  logic [ABP_W-1:0] rcnt;

  assign done = up && dn && (rcnt >= abp_eff - ABP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up   <= 1'b0;
      dn   <= 1'b0;
      rcnt <= '0;
    end else if (!en) begin
      up   <= 1'b0;
      dn   <= 1'b0;
      rcnt <= '0;
    end else if (done) begin
      up   <= ref_p;
      dn   <= fb_p;
      rcnt <= '0;
    end else begin
      up <= up | ref_p;
      dn <= dn | fb_p;
      if (up && dn) rcnt <= rcnt + ABP_W'(1);
    end
  end

  // R6
  up_from_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_p));

  // R6
  dn_from_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(fb_p));

  // R5
  overlap_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(up && dn) || $past(ref_p && fb_p));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int ABP_W  = 2,
  parameter int WID_W  = 8,
  parameter int LOCK_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  input  logic             dn,
  input  logic             done,
  input  logic [ABP_W-1:0] abp_eff,
  output logic             lock
);
  localparam int CW = $clog2(LOCK_N + 1);

  logic [WID_W-1:0] wcnt;
  logic [CW-1:0]    pcnt;
  logic [CW-1:0]    pcnt_n;
  logic             pass;

  assign pass   = wcnt <= WID_W'(abp_eff);
  assign pcnt_n = (pcnt < CW'(LOCK_N)) ? pcnt + CW'(1) : pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      pcnt <= '0;
      lock <= 1'b0;
    end else if (!en) begin
      wcnt <= '0;
      pcnt <= '0;
      lock <= 1'b0;
    end else if (done) begin
      wcnt <= '0;
      if (pass) begin
        pcnt <= pcnt_n;
        lock <= (pcnt_n >= CW'(LOCK_N));
      end else begin
        pcnt <= '0;
        lock <= 1'b0;
      end
    end else if ((up || dn) && (wcnt != '1)) begin
      wcnt <= wcnt + WID_W'(1);
    end
  end

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(done && pass));

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(!en || (done && !pass)));
endmodule

// File: rtl/pfd_synth_core.sv
module pfd_synth_core #(
  parameter int REF_W  = 14,
  parameter int FB_W   = 13,
  parameter int ABP_W  = 2,
  parameter int WID_W  = 8,
  parameter int LOCK_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             ref_tick,
  input  logic             fb_tick,
  input  logic [REF_W-1:0] r_div,
  input  logic [FB_W-1:0]  n_div,
  input  logic [ABP_W-1:0] abp_sel,
  input  logic [2:0]       mon_sel,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             pump_hiz,
  output logic             lock_flag,
  output logic             mon_out
);
  import pfd_pkg::*;

  logic             ref_p;
  logic             fb_p;
  logic             up_q;
  logic             dn_q;
  logic             cmp_done;
  logic [ABP_W-1:0] abp_eff;

  assign abp_eff = (abp_sel == '0) ? ABP_W'(1) : abp_sel;

  tick_divider #(.W(REF_W)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .tick(ref_tick),
    .div_in(r_div), .pulse(ref_p)
  );

  tick_divider #(.W(FB_W)) u_fb_div (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .tick(fb_tick),
    .div_in(n_div), .pulse(fb_p)
  );

  pfd_core #(.ABP_W(ABP_W)) u_pfd (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .ref_p(ref_p), .fb_p(fb_p),
    .abp_eff(abp_eff), .up(up_q), .dn(dn_q), .done(cmp_done)
  );

  lock_detect #(.ABP_W(ABP_W), .WID_W(WID_W), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .up(up_q), .dn(dn_q),
    .done(cmp_done), .abp_eff(abp_eff), .lock(lock_flag)
  );

  assign pump_up  = up_q && chip_en;
  assign pump_dn  = dn_q && chip_en;
  assign pump_hiz = !chip_en;

  always_comb begin
    case (mon_sel)
      MON_LOW:  mon_out = 1'b0;
      MON_LOCK: mon_out = lock_flag;
      MON_REF:  mon_out = ref_p;
      MON_FB:   mon_out = fb_p;
      default:  mon_out = 1'b1;
    endcase
  end

  // R10
  pd_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !lock_flag);
endmodule

// File: tb/pfd_synth_core_tb_top.sv
module pfd_synth_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_en;
  logic        ref_tick;
  logic        fb_tick;
  logic [13:0] r_div;
  logic [12:0] n_div;
  logic [1:0]  abp_sel;
  logic [2:0]  mon_sel;
  logic        pump_up, pump_dn, pump_hiz, lock_flag, mon_out;

  int errors = 0;
  int checks = 0;
  int exp_uw[$];
  int exp_dw[$];
  string exp_tag[$];
  int uw = 0;
  int dw = 0;
  bit in_burst = 0;
  int mon_cnt = 0;
  bit count_mon = 0;

  always #10 clk = ~clk;

  pfd_synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ref_tick(ref_tick),
    .fb_tick(fb_tick), .r_div(r_div), .n_div(n_div), .abp_sel(abp_sel),
    .mon_sel(mon_sel), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hiz(pump_hiz), .lock_flag(lock_flag), .mon_out(mon_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: measures each pump burst and compares widths
  always @(negedge clk) begin
    if (rst_n) begin
      if (pump_up || pump_dn) begin
        in_burst = 1;
        if (pump_up) uw++;
        if (pump_dn) dw++;
      end else if (in_burst) begin
        in_burst = 0;
        if (exp_uw.size() == 0) begin
          check(0, "R5 R6 unexpected burst", uw, 0);
        end else begin
          int eu, ed;
          string t;
          eu = exp_uw.pop_front();
          ed = exp_dw.pop_front();
          t  = exp_tag.pop_front();
          check(uw == eu, {t, " up width"}, uw, eu);
          check(dw == ed, {t, " dn width"}, dw, ed);
        end
        uw = 0;
        dw = 0;
      end
      if (count_mon && mon_out) mon_cnt++;
    end
  end

  function automatic int abp_now();
    return (abp_sel == 0) ? 1 : int'(abp_sel);
  endfunction

  // driver: offset d > 0 means reference leads by d cycles
  task automatic send(int d, bit cmp, string tag);
    int ad;
    ad = (d < 0) ? -d : d;
    if (cmp) begin
      exp_uw.push_back((d > 0) ? d + abp_now() : abp_now());
      exp_dw.push_back((d < 0) ? ad + abp_now() : abp_now());
      exp_tag.push_back(tag);
    end
    for (int i = 0; i <= ad; i++) begin
      ref_tick = (i == 0 && d >= 0) || (i == ad && d < 0);
      fb_tick  = (i == 0 && d <= 0) || (i == ad && d > 0);
      @(posedge clk); #1;
    end
    ref_tick = 0;
    fb_tick  = 0;
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; chip_en = 1; ref_tick = 0; fb_tick = 0;
    r_div = 1; n_div = 1; abp_sel = 1; mon_sel = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1
    check(pump_up == 0, "R1 pump_up", pump_up, 0);
    check(pump_dn == 0, "R1 pump_dn", pump_dn, 0);
    check(pump_hiz == 0, "R1 pump_hiz", pump_hiz, 0);
    check(lock_flag == 0, "R1 lock_flag", lock_flag, 0);

    // R5 aligned, R7 overlap widths
    send(0, 1, "R5");
    abp_sel = 0; send(0, 1, "R7 zero");
    abp_sel = 2; send(0, 1, "R7 two");
    abp_sel = 3; send(0, 1, "R7 three");
    abp_sel = 1;
    // R6 offsets both ways
    send(3, 1, "R6 ref lead");
    send(-2, 1, "R6 fb lead");
    check(lock_flag == 0, "R8 not locked after wide", lock_flag, 0);

    // R8 lock sequence
    for (int k = 0; k < 4; k++) send(k % 2, 1, "R8");
    check(lock_flag == 0, "R8 four passes", lock_flag, 0);
    send(0, 1, "R8");
    check(lock_flag == 1, "R8 fifth pass", lock_flag, 1);
    send(-1, 1, "R8");
    check(lock_flag == 1, "R8 stays locked", lock_flag, 1);
    check(mon_out == 1, "R9 sel lock", mon_out, 1);
    send(2, 1, "R8");
    check(lock_flag == 0, "R8 wide fails", lock_flag, 0);
    check(mon_out == 0, "R9 sel lock low", mon_out, 0);

    // R9 constant selects
    mon_sel = 0; #1 check(mon_out == 0, "R9 sel 0", mon_out, 0);
    mon_sel = 5; #1 check(mon_out == 1, "R9 sel 5", mon_out, 1);
    mon_sel = 7; #1 check(mon_out == 1, "R9 sel 7", mon_out, 1);

    // R4 new values wait for terminal count
    r_div = 3; n_div = 3; mon_sel = 2;
    mon_cnt = 0; count_mon = 1;
    send(0, 1, "R4");
    check(mon_cnt == 1, "R4 old value still used", mon_cnt, 1);
    // R2 divide by 3
    mon_cnt = 0;
    send(0, 0, ""); send(0, 0, "");
    check(mon_cnt == 0, "R2 no event before third", mon_cnt, 0);
    send(0, 1, "R2");
    check(mon_cnt == 1, "R2 event on third", mon_cnt, 1);
    // R3 divide by 3 on feedback
    mon_sel = 3; mon_cnt = 0;
    send(0, 0, ""); send(0, 0, "");
    check(mon_cnt == 0, "R3 no event before third", mon_cnt, 0);
    send(0, 1, "R3");
    check(mon_cnt == 1, "R3 event on third", mon_cnt, 1);
    // R2 R3 zero acts as one
    r_div = 0; n_div = 0; mon_sel = 2; mon_cnt = 0;
    send(0, 0, ""); send(0, 0, ""); send(0, 1, "R2");
    check(mon_cnt == 1, "R2 zero loaded at terminal", mon_cnt, 1);
    send(0, 1, "R2");
    check(mon_cnt == 2, "R2 zero divides by one", mon_cnt, 2);
    count_mon = 0;
    r_div = 1; n_div = 1;

    // R10 power-down
    for (int k = 0; k < 5; k++) send(0, 1, "R8 relock");
    check(lock_flag == 1, "R10 locked before power-down", lock_flag, 1);
    exp_uw.push_back(1); exp_dw.push_back(0); exp_tag.push_back("R10 cut");
    ref_tick = 1;
    @(posedge clk); #1 ref_tick = 0;
    repeat (2) @(posedge clk);
    #1 check(pump_up == 1, "R10 pending up", pump_up, 1);
    chip_en = 0;
    #1;
    check(pump_up == 0, "R10 up gated", pump_up, 0);
    check(pump_hiz == 1, "R10 hiz", pump_hiz, 1);
    repeat (3) @(posedge clk);
    #1 check(lock_flag == 0, "R10 lock cleared", lock_flag, 0);
    chip_en = 1;
    @(posedge clk); #1;
    send(0, 1, "R10 no stale request");

    check(exp_uw.size() == 0, "R5 all bursts seen", exp_uw.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule